// File: doc/BRIEF.md
# Antenna Diversity Switch Controller

This block drives an external two-way RF antenna switch while a receiver listens for an incoming signal. During the search, it swaps between the two antennas. Each antenna stays selected for a programmable number of clock cycles. When a qualifying event arrives, the block stops on the antenna that is selected at that moment and holds it for the rest of the packet.

The qualifying event comes from one of two sources, picked by a select input. One source is a received-strength sample compared against a threshold. The other is a preamble-detected flag from the demodulator. The lock ends on an end-of-packet or abort pulse. An acknowledge transmission freezes the switch, so a reply leaves on the antenna that heard the packet. The switch is driven by a single-ended line and by a complementary pair. A disable input parks the switch on a configurable default antenna.

Top module: `antsel_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `antOut` is 0 and `locked` is 0.
- R2: While `divEnable` is 0, `antOut` takes the value of `defaultAnt` on the next clock edge and `locked` is 0. No qualifier can lock the switch in this state.
- R3: While searching, enabled and not acknowledging, `antOut` inverts once every `dwellCycles` clock cycles. A `dwellCycles` of 0 behaves as 1.
- R4: With `qualSel` = 0, the block locks on the clock edge where `rssiValue >= rssiThresh` is seen. In this mode `preambleSeen` is ignored.
- R5: With `qualSel` = 1, the block locks on the clock edge where `preambleSeen` = 1 is seen. In this mode `rssiValue` is ignored.
- R6: While locked, `antOut` does not change, even after the qualifier goes away.
- R7: While locked, a 1 on `pktEnd` or `pktAbort` with `ackTxActive` = 0 releases the lock on the next edge. The search then restarts with a full dwell period on the current antenna.
- R8: While `ackTxActive` = 1 and the block is enabled, `antOut` and `locked` keep their values. Release pulses and dwell expiry have no effect.
- R9: `antOutP` always equals `antOut`, and `antOutN` is always its complement, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divEnable | input | 1 | 1 = diversity search active, 0 = park on the default antenna |
| defaultAnt | input | 1 | Antenna used while diversity is off |
| qualSel | input | 1 | Qualifier source: 0 = strength threshold, 1 = preamble flag |
| rssiValue | input | RSSI_W | Received strength sample |
| rssiThresh | input | RSSI_W | Strength threshold for locking |
| preambleSeen | input | 1 | Preamble-detected flag |
| dwellCycles | input | CNT_W | Cycles spent on each antenna while searching |
| pktEnd | input | 1 | End-of-packet pulse |
| pktAbort | input | 1 | Reception abort pulse |
| ackTxActive | input | 1 | Acknowledge transmission in progress |
| antOut | output | 1 | Single-ended switch control |
| antOutP | output | 1 | Differential switch control, true side |
| antOutN | output | 1 | Differential switch control, inverted side |
| locked | output | 1 | 1 while an antenna is held after qualification |

## Verification
A wrong dwell count moves an antenna edge early or late. That error shows on `antOut` within one dwell period, and the bench samples on exactly the expected cycle. A wrong lock state appears at `locked` on the edge after the qualifier or release pulse. If the lock is lost, the antenna starts toggling again within one dwell period. A broken freeze during acknowledge, or an inverted differential leg, is visible on the switch pins in the same or the next cycle.

// File: rtl/antsel_pkg.sv
package antsel_pkg;
  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCK   = 1'b1
  } antState_t;

  typedef struct packed {
    logic loadDefault;
    logic clrCnt;
    logic incCnt;
    logic toggleAnt;
  } ctrlStrobes_t;
endpackage

// File: rtl/antsel_dpath.sv
module antsel_dpath
  import antsel_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic              defaultAnt,
  input  logic [CNT_W-1:0]  dwellCycles,
  input  logic [RSSI_W-1:0] rssiValue,
  input  logic [RSSI_W-1:0] rssiThresh,
  output logic              rssiOk,
  output logic              dwellDone,
  output logic              antState
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] dwellCnt;
  logic [EXT_W-1:0] cntPlusOne;

  // One more than the current count, widened so the compare cannot overflow.
  assign cntPlusOne = {1'b0, dwellCnt} + EXT_W'(1);
  // A dwell setting of 0 ends the period at once, the same as a setting of 1.
  assign dwellDone  = cntPlusOne >= {1'b0, dwellCycles};
  assign rssiOk     = rssiValue >= rssiThresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwellCnt <= '0;
    end else if (strb.clrCnt) begin
      dwellCnt <= '0;
    end else if (strb.incCnt) begin
      dwellCnt <= dwellCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      antState <= 1'b0;
    end else if (strb.loadDefault) begin
      antState <= defaultAnt;
    end else if (strb.toggleAnt) begin
      antState <= ~antState;
    end
  end
endmodule

// File: rtl/antsel_ctrl.sv
module antsel_ctrl
  import antsel_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         divEnable,
  input  logic         qualSel,
  input  logic         preambleSeen,
  input  logic         rssiOk,
  input  logic         dwellDone,
  input  logic         pktEnd,
  input  logic         pktAbort,
  input  logic         ackTxActive,
  output ctrlStrobes_t strb,
  output logic         locked
);
  antState_t state, nextState;
  logic      qualified;

  assign qualified = qualSel ? preambleSeen : rssiOk;

  always_comb begin
    strb      = '0;
    nextState = state;
    if (!divEnable) begin
      strb.loadDefault = 1'b1;
      strb.clrCnt      = 1'b1;
      nextState        = ST_SEARCH;
    end else if (ackTxActive) begin
      // Acknowledge in progress: the switch and the lock stay where they are.
      nextState = state;
    end else if (state == ST_LOCK) begin
      if (pktEnd || pktAbort) begin
        strb.clrCnt = 1'b1;
        nextState   = ST_SEARCH;
      end
    end else if (qualified) begin
      strb.clrCnt = 1'b1;
      nextState   = ST_LOCK;
    end else if (dwellDone) begin
      strb.toggleAnt = 1'b1;
      strb.clrCnt    = 1'b1;
    end else begin
      strb.incCnt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= nextState;
  end

  assign locked = (state == ST_LOCK);
endmodule

// File: rtl/antsel_top.sv
module antsel_top
  import antsel_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              divEnable,
  input  logic              defaultAnt,
  input  logic              qualSel,
  input  logic [RSSI_W-1:0] rssiValue,
  input  logic [RSSI_W-1:0] rssiThresh,
  input  logic              preambleSeen,
  input  logic [CNT_W-1:0]  dwellCycles,
  input  logic              pktEnd,
  input  logic              pktAbort,
  input  logic              ackTxActive,
  output logic              antOut,
  output logic              antOutP,
  output logic              antOutN,
  output logic              locked
);
  ctrlStrobes_t strb;
  logic         rssiOk;
  logic         dwellDone;
  logic         antState;

  antsel_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .divEnable    (divEnable),
    .qualSel      (qualSel),
    .preambleSeen (preambleSeen),
    .rssiOk       (rssiOk),
    .dwellDone    (dwellDone),
    .pktEnd       (pktEnd),
    .pktAbort     (pktAbort),
    .ackTxActive  (ackTxActive),
    .strb         (strb),
    .locked       (locked)
  );

  antsel_dpath #(.RSSI_W(RSSI_W), .CNT_W(CNT_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .defaultAnt  (defaultAnt),
    .dwellCycles (dwellCycles),
    .rssiValue   (rssiValue),
    .rssiThresh  (rssiThresh),
    .rssiOk      (rssiOk),
    .dwellDone   (dwellDone),
    .antState    (antState)
  );

  // All three switch lines come from one register, so they always change together.
  assign antOut  = antState;
  assign antOutP = antState;
  assign antOutN = ~antState;
endmodule

// File: rtl/antsel_checker.sv
module antsel_checker #(
  parameter int RSSI_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              divEnable,
  input logic              defaultAnt,
  input logic              qualSel,
  input logic [RSSI_W-1:0] rssiValue,
  input logic [RSSI_W-1:0] rssiThresh,
  input logic              preambleSeen,
  input logic              pktEnd,
  input logic              pktAbort,
  input logic              ackTxActive,
  input logic              antOut,
  input logic              antOutP,
  input logic              antOutN,
  input logic              locked
);
  assert_diff_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
    (antOutP == antOut) && (antOutN == ~antOut));

  assert_disabled_default_R2: assert property (@(posedge clk) disable iff (!rstN)
    !divEnable |=> (!locked && antOut == $past(defaultAnt)));

  assert_rssi_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    (divEnable && !locked && !ackTxActive && !qualSel && (rssiValue >= rssiThresh))
      |=> locked);

  assert_preamble_lock_R5: assert property (@(posedge clk) disable iff (!rstN)
    (divEnable && !locked && !ackTxActive && qualSel && preambleSeen) |=> locked);

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (divEnable && locked && !pktEnd && !pktAbort)
      |=> (locked && antOut == $past(antOut)));

  assert_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (divEnable && locked && !ackTxActive && (pktEnd || pktAbort)) |=> !locked);

  assert_ack_freeze_R8: assert property (@(posedge clk) disable iff (!rstN)
    (divEnable && ackTxActive)
      |=> (antOut == $past(antOut) && locked == $past(locked)));
endmodule

bind antsel_top antsel_checker #(.RSSI_W(RSSI_W)) u_checker (
  .clk          (clk),
  .rstN         (rstN),
  .divEnable    (divEnable),
  .defaultAnt   (defaultAnt),
  .qualSel      (qualSel),
  .rssiValue    (rssiValue),
  .rssiThresh   (rssiThresh),
  .preambleSeen (preambleSeen),
  .pktEnd       (pktEnd),
  .pktAbort     (pktAbort),
  .ackTxActive  (ackTxActive),
  .antOut       (antOut),
  .antOutP      (antOutP),
  .antOutN      (antOutN),
  .locked       (locked)
);

// File: tb/sim_antsel_top.sv
module sim_antsel_top;
  localparam int RSSI_W = 8;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic       en;
    logic       def;
    logic       sel;
    logic [7:0] rssi;
    logic       pre;
    logic       pend;
    logic       pabort;
    logic       ack;
    logic [7:0] cyc;
    logic       expAnt;
    logic       expLock;
  } vec_t;

  // dwellCycles = 4, rssiThresh = 100 throughout the table.
  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0,1'b1,1'b0,8'd0,  1'b0,1'b0,1'b0,1'b0,8'd2,1'b1,1'b0}, // R2 default 1
    '{1'b1,1'b1,1'b0,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd3,1'b1,1'b0}, // R3/R4 preamble ignored
    '{1'b1,1'b1,1'b0,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd1,1'b0,1'b0}, // R3 toggle on 4th
    '{1'b1,1'b1,1'b0,8'd0,  1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0}, // R3 next period
    '{1'b1,1'b1,1'b0,8'd150,1'b0,1'b0,1'b0,1'b0,8'd1,1'b1,1'b1}, // R4 lock
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b0,8'd6,1'b1,1'b1}, // R6 hold
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b1,1'b0,1'b1,8'd2,1'b1,1'b1}, // R8 end blocked
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b1,1'b0,1'b0,8'd1,1'b1,1'b0}, // R7 release
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b0,8'd3,1'b1,1'b0}, // R7 fresh count
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b1,8'd3,1'b1,1'b0}, // R8 freeze search
    '{1'b1,1'b1,1'b0,8'd50, 1'b0,1'b0,1'b0,1'b0,8'd1,1'b0,1'b0}, // R8 count kept
    '{1'b1,1'b1,1'b1,8'd200,1'b0,1'b0,1'b0,1'b0,8'd4,1'b1,1'b0}, // R5 rssi ignored
    '{1'b1,1'b1,1'b1,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd1,1'b1,1'b1}, // R5 lock
    '{1'b1,1'b1,1'b1,8'd0,  1'b0,1'b0,1'b1,1'b0,8'd1,1'b1,1'b0}, // R7 abort
    '{1'b0,1'b0,1'b1,8'd0,  1'b0,1'b0,1'b0,1'b0,8'd1,1'b0,1'b0}, // R2 default 0
    '{1'b0,1'b0,1'b1,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd2,1'b0,1'b0}, // R2 no lock
    '{1'b1,1'b0,1'b1,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd1,1'b0,1'b1}, // R5 lock on 0
    '{1'b0,1'b1,1'b1,8'd0,  1'b1,1'b0,1'b0,1'b0,8'd1,1'b1,1'b0}  // R2 disable unlocks
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              divEnable = 1'b0;
  logic              defaultAnt = 1'b0;
  logic              qualSel = 1'b0;
  logic [RSSI_W-1:0] rssiValue = '0;
  logic [RSSI_W-1:0] rssiThresh = 8'd100;
  logic              preambleSeen = 1'b0;
  logic [CNT_W-1:0]  dwellCycles = 16'd4;
  logic              pktEnd = 1'b0;
  logic              pktAbort = 1'b0;
  logic              ackTxActive = 1'b0;
  logic              antOut, antOutP, antOutN, locked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  antsel_top #(.RSSI_W(RSSI_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .divEnable(divEnable), .defaultAnt(defaultAnt),
    .qualSel(qualSel), .rssiValue(rssiValue), .rssiThresh(rssiThresh),
    .preambleSeen(preambleSeen), .dwellCycles(dwellCycles), .pktEnd(pktEnd),
    .pktAbort(pktAbort), .ackTxActive(ackTxActive), .antOut(antOut),
    .antOutP(antOutP), .antOutN(antOutN), .locked(locked)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic checkOuts(input string req, input logic expAnt, input logic expLock);
    check(req, "antOut", antOut, expAnt);
    check(req, "locked", locked, expLock);
    check("R9", "antOutP", antOutP, expAnt);
    check("R9", "antOutN", antOutN, ~expAnt);
  endtask

  initial begin
    #3;
    checkOuts("R1", 1'b0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    checkOuts("R1", 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      divEnable    = VECS[i].en;
      defaultAnt   = VECS[i].def;
      qualSel      = VECS[i].sel;
      rssiValue    = VECS[i].rssi;
      preambleSeen = VECS[i].pre;
      pktEnd       = VECS[i].pend;
      pktAbort     = VECS[i].pabort;
      ackTxActive  = VECS[i].ack;
      repeat (int'(VECS[i].cyc)) @(posedge clk);
      #1;
      checkOuts($sformatf("vector %0d", i), VECS[i].expAnt, VECS[i].expLock);
    end

    // R3: dwell of 1 and of 0 both toggle on every edge.
    @(negedge clk);
    divEnable = 1'b0; defaultAnt = 1'b0; preambleSeen = 1'b0;
    @(negedge clk);
    divEnable = 1'b1; qualSel = 1'b1; dwellCycles = 16'd1;
    @(posedge clk); #1;
    check("R3", "dwell1 first", antOut, 1'b1);
    @(posedge clk); #1;
    check("R3", "dwell1 second", antOut, 1'b0);
    @(negedge clk);
    dwellCycles = 16'd0;
    @(posedge clk); #1;
    check("R3", "dwell0 first", antOut, 1'b1);
    @(posedge clk); #1;
    check("R3", "dwell0 second", antOut, 1'b0);

    // R1: reset in the middle of a lock.
    @(negedge clk);
    preambleSeen = 1'b1;
    @(posedge clk); #1;
    check("R5", "lock before reset", locked, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOuts("R1", 1'b0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule